// File: doc/BRIEF.md
# Glitchless Output Enable Controller

This block sits between a bank of clock sources and the clock output pins. Each output lane has its own input clock. The lane runs its clock out to the pin when it is enabled. When it is disabled, the pin is parked in a programmable idle state.

The enable decision combines three things:
- a shared, active-low enable pin;
- a per-lane mask that decides whether that pin matters to the lane;
- a per-lane software disable bit.

A per-lane 2-bit code picks what a disabled lane does. Every request is first synchronised into the lane's own clock domain. The gate then opens or closes only at a phase boundary where the switch cannot cut a pulse short. A per-lane invert bit flips the clock presented at the pin. The idle levels are absolute and do not depend on the invert bit.

The configuration inputs (mask, software disable, invert and code) are treated as quasi-static. The enable pin is the run-time control.

Top module: `glitchless_oe_ctl`

## Requirements
- R1: With its mask bit at 0, its software disable bit at 0 and a code other than 3, a lane runs while `oe_pin_ni` is 0 and is idle while `oe_pin_ni` is 1.
- R2: A lane whose `pin_mask_i` bit is 1 ignores `oe_pin_ni`: it runs whenever its software disable bit is 0.
- R3: A lane whose `sw_dis_i` bit is 1 is idle whatever the level of `oe_pin_ni`, unless its code is 3.
- R4: The idle state follows the lane's 2-bit code in `dis_state_i[2k+1:2k]`:
  - 0: `clk_o` low and `clk_oe_o` 1.
  - 1: `clk_o` high and `clk_oe_o` 1.
  - 2: `clk_oe_o` 0 and `clk_o` low.
  - `clk_oe_o` is 0 only in code 2.
- R5: A lane with code 3 runs whatever `oe_pin_ni`, `pin_mask_i` and `sw_dis_i` say, with `clk_oe_o` at 1.
- R6: A running lane with its `inv_i` bit at 1 presents the complement of its input clock. The idle levels of R4 are the same for either value of `inv_i`.
- R7: A change of a lane's enable request that is applied between two rising edges takes effect at the third rising edge of that lane's clock that follows. The high and low phases of the first two cycles still show the previous state at `clk_o`. `clk_oe_o` has switched by the third rising edge.
- R8: Across enabling and disabling, every high level and every low level at `clk_o` lasts at least half a clock period.
- R9: While `rst_ni` is 0, every lane sits in its idle state. A code-3 lane starts running at the third rising edge after reset is released. Other lanes stay idle until they are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NUM_OUT | Per-lane source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_pin_ni | input | 1 | Shared enable pin, active low |
| sw_dis_i | input | NUM_OUT | Per-lane software disable, 1 = off |
| pin_mask_i | input | NUM_OUT | Per-lane pin mask, 1 = pin ignored |
| inv_i | input | NUM_OUT | Per-lane clock invert |
| dis_state_i | input | 2*NUM_OUT | Per-lane idle code (0 low, 1 high, 2 high-Z, 3 never off) |
| clk_o | output | NUM_OUT | Gated clock to the pin |
| clk_oe_o | output | NUM_OUT | Pin driver enable, 0 = high impedance |

## Verification
A request passes two synchroniser flops at rising edges 1 and 2. The gate flop then updates at the falling edge after edge 2 or at edge 3, so the new clock state is first visible in the high phase that begins at the third rising edge.

The bench drives every input 1 ns after a rising edge. It samples 1.25 ns into each high phase and each low phase, and holds the expected state at its old value for the first two cycles. Only the enable flag is excused in the low phase of cycle 2, because lanes that switch on the falling edge change it there.

Steady-state checks wait four rising edges after any change. A timestamp monitor measures each level segment at the pins while requests switch.

// File: rtl/oe_ctl_pkg.sv
`timescale 1ns/1ps
package oe_ctl_pkg;

  typedef enum logic [1:0] {
    IDLE_LOW  = 2'b00,
    IDLE_HIGH = 2'b01,
    IDLE_HIZ  = 2'b10,
    IDLE_NONE = 2'b11
  } idle_mode_e;

endpackage

// File: rtl/oe_sync.sv
`timescale 1ns/1ps
module oe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/oe_gate.sv
`timescale 1ns/1ps
module oe_gate
  import oe_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       inv_i,
  input  idle_mode_e mode_i,
  output logic       clk_o,
  output logic       oe_o
);

  logic idle_lvl;
  logic use_pos;
  logic gate_pos_q, gate_neg_q, gate;
  logic clk_pres;

  assign idle_lvl = (mode_i == IDLE_HIGH);
  // switch only while the presented clock already sits at the idle level
  assign use_pos  = inv_i ^ idle_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_pos_q <= 1'b0;
    else         gate_pos_q <= en_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_neg_q <= 1'b0;
    else         gate_neg_q <= en_i;
  end

  assign gate     = use_pos ? gate_pos_q : gate_neg_q;
  assign clk_pres = clk_i ^ inv_i;
  assign clk_o    = gate ? clk_pres : idle_lvl;
  assign oe_o     = gate | (mode_i != IDLE_HIZ);

endmodule

// File: rtl/oe_lane.sv
`timescale 1ns/1ps
module oe_lane
  import oe_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_ni,
  input  logic       sw_dis_i,
  input  logic       pin_mask_i,
  input  logic       inv_i,
  input  idle_mode_e mode_i,
  output logic       clk_o,
  output logic       oe_o
);

  logic pin_off, req, req_s;

  assign pin_off = !pin_mask_i && pin_ni;
  assign req     = (mode_i == IDLE_NONE) || !(sw_dis_i || pin_off);

  oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req),
    .q_o    (req_s)
  );

  oe_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (req_s),
    .inv_i  (inv_i),
    .mode_i (mode_i),
    .clk_o  (clk_o),
    .oe_o   (oe_o)
  );

endmodule

// File: rtl/glitchless_oe_ctl.sv
`timescale 1ns/1ps
module glitchless_oe_ctl
  import oe_ctl_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_OUT-1:0]   clk_i,
  input  logic                 rst_ni,
  input  logic                 oe_pin_ni,
  input  logic [NUM_OUT-1:0]   sw_dis_i,
  input  logic [NUM_OUT-1:0]   pin_mask_i,
  input  logic [NUM_OUT-1:0]   inv_i,
  input  logic [2*NUM_OUT-1:0] dis_state_i,
  output logic [NUM_OUT-1:0]   clk_o,
  output logic [NUM_OUT-1:0]   clk_oe_o
);

  localparam int CodeW = $bits(idle_mode_e);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    oe_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .clk_i      (clk_i[k]),
      .rst_ni     (rst_ni),
      .pin_ni     (oe_pin_ni),
      .sw_dis_i   (sw_dis_i[k]),
      .pin_mask_i (pin_mask_i[k]),
      .inv_i      (inv_i[k]),
      .mode_i     (idle_mode_e'(dis_state_i[CodeW*k +: CodeW])),
      .clk_o      (clk_o[k]),
      .oe_o       (clk_oe_o[k])
    );
  end

endmodule

// File: rtl/glitchless_oe_ctl_chk.sv
`timescale 1ns/1ps
module glitchless_oe_ctl_chk #(
  parameter int NUM_OUT = 8
) (
  input logic [NUM_OUT-1:0]   clk_i,
  input logic                 rst_ni,
  input logic                 oe_pin_ni,
  input logic [NUM_OUT-1:0]   sw_dis_i,
  input logic [NUM_OUT-1:0]   pin_mask_i,
  input logic [NUM_OUT-1:0]   inv_i,
  input logic [2*NUM_OUT-1:0] dis_state_i,
  input logic [NUM_OUT-1:0]   clk_o,
  input logic [NUM_OUT-1:0]   clk_oe_o
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    logic [1:0] cnt_q;
    logic [5:0] cfg;

    // rising edges seen since reset, saturating at 3
    always_ff @(posedge clk_i[k] or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= 2'd0;
      else if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
    end

    // {sw_dis, mask, pin, inv, code}
    assign cfg = {sw_dis_i[k], pin_mask_i[k], oe_pin_ni, inv_i[k], dis_state_i[2*k +: 2]};

    p_pin_off_r1: assert property (@(negedge clk_i[k]) disable iff (!rst_ni)
      (cnt_q == 2'd3 && cfg ==? 6'b001?00 && cfg == $past(cfg, 1) && cfg == $past(cfg, 2)
       && cfg == $past(cfg, 3)) |-> (!clk_o[k] && clk_oe_o[k]));

    p_mask_runs_r2: assert property (@(negedge clk_i[k]) disable iff (!rst_ni)
      (cnt_q == 2'd3 && cfg ==? 6'b01?000 && cfg == $past(cfg, 1) && cfg == $past(cfg, 2)
       && cfg == $past(cfg, 3)) |-> clk_o[k]);

    p_soft_off_r3: assert property (@(negedge clk_i[k]) disable iff (!rst_ni)
      (cnt_q == 2'd3 && cfg ==? 6'b1???00 && cfg == $past(cfg, 1) && cfg == $past(cfg, 2)
       && cfg == $past(cfg, 3)) |-> (!clk_o[k] && clk_oe_o[k]));

    p_idle_high_r4: assert property (@(posedge clk_i[k]) disable iff (!rst_ni)
      (cnt_q == 2'd3 && cfg ==? 6'b1??001 && cfg == $past(cfg, 1) && cfg == $past(cfg, 2)
       && cfg == $past(cfg, 3)) |-> (clk_o[k] && clk_oe_o[k]));

    p_hiz_off_r4: assert property (@(posedge clk_i[k]) disable iff (!rst_ni)
      (cnt_q == 2'd3 && cfg ==? 6'b1???10 && cfg == $past(cfg, 1) && cfg == $past(cfg, 2)
       && cfg == $past(cfg, 3)) |-> !clk_oe_o[k]);

    p_hiz_code_r4: assert property (@(posedge clk_i[k]) disable iff (!rst_ni)
      !clk_oe_o[k] |-> (dis_state_i[2*k +: 2] == 2'b10));

    // R5 and R6: code 3 keeps running, high phase shows the inverted level when inv is set
    p_always_on_r5: assert property (@(negedge clk_i[k]) disable iff (!rst_ni)
      (cnt_q == 2'd3 && cfg ==? 6'b????11 && cfg == $past(cfg, 1) && cfg == $past(cfg, 2)
       && cfg == $past(cfg, 3)) |-> (clk_o[k] == !inv_i[k] && clk_oe_o[k]));
  end

endmodule

bind glitchless_oe_ctl glitchless_oe_ctl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .oe_pin_ni   (oe_pin_ni),
  .sw_dis_i    (sw_dis_i),
  .pin_mask_i  (pin_mask_i),
  .inv_i       (inv_i),
  .dis_state_i (dis_state_i),
  .clk_o       (clk_o),
  .clk_oe_o    (clk_oe_o)
);

// File: tb/tb_glitchless_oe_ctl.sv
`timescale 1ns/1ps
module tb_glitchless_oe_ctl;
  localparam int N = 8;
  localparam realtime HALF = 2.5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic           pin_n;
  logic [N-1:0]   sw, mask, inv;
  logic [2*N-1:0] mode;
  logic [N-1:0]   clk_i;
  logic [N-1:0]   clk_o, oe_o;
  assign clk_i = {N{clk}};

  // model copy of the request the outputs should reflect
  logic           m_pin;
  logic [N-1:0]   m_sw, m_mask, m_inv;
  logic [2*N-1:0] m_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  glitchless_oe_ctl #(.NUM_OUT(N)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .oe_pin_ni(pin_n), .sw_dis_i(sw),
    .pin_mask_i(mask), .inv_i(inv), .dis_state_i(mode),
    .clk_o(clk_o), .clk_oe_o(oe_o)
  );

  // level segment monitor (R8)
  logic [N-1:0] prev_o;
  realtime      t_last [N];
  bit           seen [N];
  bit           mon_en = 0;
  int           runts = 0, edges = 0;

  always @(clk_o) begin
    for (int k = 0; k < N; k++) begin
      if (clk_o[k] !== prev_o[k] && mon_en) begin
        if (seen[k] && ($realtime - t_last[k]) < HALF - 0.1) runts++;
        edges++;
        seen[k]   = 1'b1;
        t_last[k] = $realtime;
      end
    end
    prev_o = clk_o;
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic commit();
    m_pin = pin_n; m_sw = sw; m_mask = mask; m_inv = inv; m_mode = mode;
  endtask

  function automatic bit exp_run(input int k);
    return (m_mode[2*k +: 2] == 2'b11) || !(m_sw[k] || (!m_mask[k] && m_pin));
  endfunction

  task automatic check_phase(input bit hi, input bit force_idle, input bit do_oe, input string req);
    for (int k = 0; k < N; k++) begin
      bit run;
      logic [1:0] code;
      logic e_clk, e_oe;
      run   = exp_run(k) && !force_idle;
      code  = m_mode[2*k +: 2];
      e_clk = run ? (hi ^ m_inv[k]) : (code == 2'b01);
      e_oe  = run || (code != 2'b10);
      chk(req, $sformatf("lane%0d clk_o %s", k, hi ? "high phase" : "low phase"), clk_o[k], e_clk);
      if (do_oe) chk(req, $sformatf("lane%0d clk_oe_o", k), oe_o[k], e_oe);
    end
  endtask

  task automatic sample_cycle(input bit force_idle, input bit oe_lo, input string req);
    @(posedge clk); #1.25;
    check_phase(1'b1, force_idle, 1'b1, req);
    @(negedge clk); #1.25;
    check_phase(1'b0, force_idle, oe_lo, req);
  endtask

  task automatic settle_check(input string req);
    repeat (4) @(posedge clk);
    commit();
    sample_cycle(1'b0, 1'b1, req);
    sample_cycle(1'b0, 1'b1, req);
  endtask

  task automatic at_edge();
    @(posedge clk); #1;
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk);
    #1.25 check_phase(1'b1, 1'b1, 1'b1, "R9 reset idle (R4 codes)");
    @(negedge clk); #1.25 check_phase(1'b0, 1'b1, 1'b1, "R9 reset idle (R4 codes)");
    at_edge();
    rst_ni = 1'b1;
    for (int c = 1; c <= 3; c++) sample_cycle(c < 3, 1'b1, "R9 release, code-3 lanes start (R5)");
    sample_cycle(1'b0, 1'b1, "R9 R4 idle after release");
  endtask

  task automatic test_pin();
    at_edge(); pin_n = 1'b0;
    settle_check("R1 pin low runs");
    at_edge(); pin_n = 1'b1;
    settle_check("R1 pin high idles (R4)");
  endtask

  task automatic test_mask();
    at_edge(); mask = 8'hF0; pin_n = 1'b1;
    settle_check("R2 masked lanes ignore pin high");
    at_edge(); pin_n = 1'b0;
    settle_check("R2 masked lanes with pin low");
    at_edge(); mask = 8'h00;
  endtask

  task automatic test_sw();
    at_edge(); pin_n = 1'b0; sw = 8'hCC;
    settle_check("R3 soft disable, R5 code 3 unaffected");
    at_edge(); sw = 8'hFF; pin_n = 1'b1; mask = 8'h55;
    settle_check("R5 code 3 runs with all disables");
    at_edge(); sw = 8'h00; mask = 8'h00;
  endtask

  task automatic test_invert();
    at_edge(); inv = 8'hA5; pin_n = 1'b0;
    settle_check("R6 inverted running clocks");
    at_edge(); pin_n = 1'b1;
    settle_check("R6 idle levels independent of invert");
  endtask

  task automatic run_step(input logic new_pin, input string req);
    at_edge(); pin_n = new_pin;
    for (int c = 1; c <= 4; c++) begin
      @(posedge clk); #1.25;
      if (c == 3) commit();
      check_phase(1'b1, 1'b0, 1'b1, req);
      @(negedge clk); #1.25;
      check_phase(1'b0, 1'b0, c != 2, req);
    end
  endtask

  task automatic test_latency();
    at_edge(); inv = 8'h5A; pin_n = 1'b1;
    repeat (4) @(posedge clk);
    commit();
    for (int k = 0; k < N; k++) seen[k] = 1'b0;
    mon_en = 1'b1;
    run_step(1'b0, "R7 enable on third rising edge");
    run_step(1'b1, "R7 disable on third rising edge");
    at_edge(); mode = 16'h1B1B; inv = 8'h0F;
    repeat (4) @(posedge clk);
    commit();
    for (int k = 0; k < N; k++) seen[k] = 1'b0;
    run_step(1'b0, "R7 enable, second code mix");
    run_step(1'b1, "R7 disable, second code mix");
    mon_en = 1'b0;
    chk("R8", "short level segments", runts == 0, 1'b1);
    chk("R8", "edges observed", edges > 0, 1'b1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    pin_n = 1'b1; sw = '0; mask = '0; inv = '0;
    mode  = 16'hE4E4;  // lane k code = k mod 4
    commit();
    test_reset();
    test_pin();
    test_mask();
    test_sw();
    test_invert();
    test_latency();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: got run still active expected completion");
      summary();
      $finish;
    end
  end

endmodule